// File: doc/BRIEF.md
# Completion Timeout and Error Collector

This block watches over the commands that a storage host controller sends to its drives and gathers every failure it sees into a single sticky error word. When a command goes out, a start pulse arms a wait timer with a programmable limit counted in clock cycles. A completion pulse disarms the timer. If the limit is reached first, an admin or I/O timeout is recorded, depending on which kind of command was pending.

Alongside the timer, the block does three more jobs. It checks the controller capability fields presented once during bring-up, and keeps a packed copy of them. It latches the status word of every admin and I/O completion and flags any that are not clean. It also turns strobes from the packet layer and from the drive scan into error bits.

All error state is sticky until reset. A summary flag reports whether any error bit is set. A device index records which drive was selected when the first error appeared.

Top module: `cmpl_err_collector`

## Requirements
- R1: After reset the error vector, summary flag, failing-device index, capability snapshot and both status words are all zero.
- R2: A capability strobe sets error bit 1 when any of these holds: the minimum page size field is nonzero, the command-set flag is 0, the doorbell stride is nonzero, or the queue-entries field is 7 or more. Otherwise bit 1 stays clear.
- R3: On every capability strobe, the snapshot takes the queue-entries field in [15:0], the stride in [19:16], the command-set flag in [20] and the minimum page size in [24:21]. Bits [31:25] read 0.
- R4: An admin completion strobe loads the admin status word with the invalid-tag flag in bit 0 and the 15-bit status in [15:1]. If that word is nonzero, error bit 3 is set.
- R5: An I/O completion strobe loads the I/O status word with the invalid-phase flag in bit 0 and the 15-bit status in [15:1]. If that word is nonzero, error bit 5 is set.
- R6: With a nonzero limit L captured at a start pulse, and no completion, the timeout bit appears in the error vector L clock edges after the start edge and not before. The bit is 2 for an admin wait and 4 for an I/O wait.
- R7: A completion pulse on or before the L-th edge after the start cancels the timeout. A limit of 0 disables the timeout.
- R8: Each of the following strobes sets one error bit:
  - a bad completion packet size sets bit 6;
  - a receive-buffer ECC fault sets bit 7;
  - an unsupported-request completion sets bit 8;
  - a completer-abort completion sets bit 9;
  - an unsupported sector size sets bit 16.
- R9: A scan-done strobe while the live-drive mask is zero sets error bit 0. The mask falling to zero later, with no scan strobe, leaves bit 0 clear.
- R10: Error bits never clear except by reset. Bits 10 to 15 and 17 to 31 are always zero.
- R11: The summary flag equals the OR of the error vector in every cycle.
- R12: The failing-device index takes the device select of the cycle in which the first error bit is set, and holds it afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_sel | input | 2 | Currently selected drive |
| timeout_limit | input | 32 | Timeout in clock cycles, 0 disables |
| wait_start | input | 1 | Pulse: a command was issued, arm the timer |
| wait_is_io | input | 1 | Kind of command issued with wait_start (1 = I/O) |
| cpl_seen | input | 1 | Pulse: completion received, disarm the timer |
| cap_valid | input | 1 | Capability fields valid strobe |
| cap_mqes | input | 16 | Maximum queue entries field |
| cap_dstrd | input | 4 | Doorbell stride field |
| cap_nvm_set | input | 1 | Command-set supported flag |
| cap_mpsmin | input | 4 | Minimum memory page size field |
| adm_cpl_valid | input | 1 | Admin completion status strobe |
| adm_status | input | 15 | Admin completion status field |
| adm_bad_id | input | 1 | Admin completion phase/ID mismatch |
| io_cpl_valid | input | 1 | I/O completion status strobe |
| io_status | input | 15 | I/O completion status field |
| io_bad_phase | input | 1 | I/O completion phase mismatch |
| tlp_len_err | input | 1 | Completion packet size wrong |
| rx_ecc_err | input | 1 | Receive buffer ECC fault |
| ur_err | input | 1 | Unsupported-request completion |
| ca_err | input | 1 | Completer-abort completion |
| lba_unsup | input | 1 | Unsupported sector size |
| scan_done | input | 1 | Drive scan finished strobe |
| dev_live | input | 4 | Mask of drives in service |
| err_type | output | 32 | Sticky error vector |
| err_any | output | 1 | OR of the error vector |
| err_dev | output | 2 | Device selected at first error |
| cap_snap | output | 32 | Packed capability snapshot |
| adm_word | output | 16 | Latched admin completion status |
| io_word | output | 16 | Latched I/O completion status |

## Verification
Because the error bits are sticky, any bit set by one trial would hide the result of the next. The hardest thing to drive from the ports is therefore a large number of independent timing outcomes, and the bench resets between trials so that each one starts from a clean vector. The timer sweep covers every limit from 1 to 6 for both command kinds. In each case the completion is placed on every edge from the first to two past the limit, and the vector is sampled on the edge just before the limit and on the limit edge itself, so that both the exact expiry cycle and the tie where the completion arrives on the limit edge are pinned down. The capability check is swept over a grid that crosses every field over its pass/fail boundary.

// File: rtl/cep_pkg.sv
package cep_pkg;
  localparam int ERR_W     = 32;
  localparam int TO_W      = 32;
  localparam int MQES_W    = 16;
  localparam int DSTRD_W   = 4;
  localparam int MPS_W     = 4;
  localparam int STAT_W    = 15;
  localparam int WORD_W    = STAT_W + 1;
  localparam int MQES_LIM  = 7;

  localparam int B_NODEV   = 0;
  localparam int B_CAP     = 1;
  localparam int B_ADM_TO  = 2;
  localparam int B_ADM_ST  = 3;
  localparam int B_IO_TO   = 4;
  localparam int B_IO_ST   = 5;
  localparam int B_TLPLEN  = 6;
  localparam int B_ECC     = 7;
  localparam int B_UR      = 8;
  localparam int B_CA      = 9;
  localparam int B_LBA     = 16;

  localparam logic [ERR_W-1:0] ERR_MASK = ERR_W'((1 << B_LBA) | 32'h3FF);

  function automatic logic cap_bad(input logic [MQES_W-1:0] mqes,
                                   input logic [DSTRD_W-1:0] dstrd,
                                   input logic nvm,
                                   input logic [MPS_W-1:0] mps);
    return (mps != '0) || !nvm || (dstrd != '0) || (mqes >= MQES_W'(MQES_LIM));
  endfunction

  function automatic logic [31:0] cap_pack(input logic [MQES_W-1:0] mqes,
                                           input logic [DSTRD_W-1:0] dstrd,
                                           input logic nvm,
                                           input logic [MPS_W-1:0] mps);
    logic [31:0] w;
    w        = '0;
    w[15:0]  = mqes;
    w[19:16] = dstrd;
    w[20]    = nvm;
    w[24:21] = mps;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] stat_word(input logic [STAT_W-1:0] st,
                                                  input logic flag);
    return {st, flag};
  endfunction
endpackage

// File: rtl/cep_cap_check.sv
module cep_cap_check
  import cep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [MQES_W-1:0] cap_mqes,
  input  logic [DSTRD_W-1:0] cap_dstrd,
  input  logic              cap_nvm_set,
  input  logic [MPS_W-1:0]  cap_mpsmin,
  output logic              fail_evt,
  output logic [31:0]       snap
);
  assign fail_evt = cap_valid && cap_bad(cap_mqes, cap_dstrd, cap_nvm_set, cap_mpsmin);

  always_ff @(posedge clk) begin
    if (!rst_n) snap <= '0;
    else if (cap_valid) snap <= cap_pack(cap_mqes, cap_dstrd, cap_nvm_set, cap_mpsmin);
  end
endmodule

// File: rtl/cep_cpl_latch.sv
module cep_cpl_latch
  import cep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [STAT_W-1:0] status,
  input  logic              bad_tag,
  output logic              bad_evt,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] incoming;
  assign incoming = stat_word(status, bad_tag);
  assign bad_evt  = valid && (incoming != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (valid) word <= incoming;
  end
endmodule

// File: rtl/cep_wait_timer.sv
module cep_wait_timer
  import cep_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] limit_in,
  input  logic            start,
  input  logic            start_is_io,
  input  logic            done,
  output logic            armed,
  output logic            adm_expire,
  output logic            io_expire
);
  logic [TO_W-1:0] cnt;
  logic [TO_W-1:0] lim;
  logic            pend_io;
  logic            expire;

  assign expire     = armed && !start && !done && (cnt == lim - TO_W'(1));
  assign adm_expire = expire && !pend_io;
  assign io_expire  = expire && pend_io;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      lim     <= '0;
      armed   <= 1'b0;
      pend_io <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      lim     <= limit_in;
      armed   <= (limit_in != '0);
      pend_io <= start_is_io;
    end else if (done || expire) begin
      armed   <= 1'b0;
    end else if (armed) begin
      cnt     <= cnt + TO_W'(1);
    end
  end
endmodule

// File: rtl/cmpl_err_collector.sv
module cmpl_err_collector
  import cep_pkg::*;
#(
  parameter int NDEV  = 4,
  localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEV_W-1:0]   dev_sel,
  input  logic [TO_W-1:0]    timeout_limit,
  input  logic               wait_start,
  input  logic               wait_is_io,
  input  logic               cpl_seen,
  input  logic               cap_valid,
  input  logic [MQES_W-1:0]  cap_mqes,
  input  logic [DSTRD_W-1:0] cap_dstrd,
  input  logic               cap_nvm_set,
  input  logic [MPS_W-1:0]   cap_mpsmin,
  input  logic               adm_cpl_valid,
  input  logic [STAT_W-1:0]  adm_status,
  input  logic               adm_bad_id,
  input  logic               io_cpl_valid,
  input  logic [STAT_W-1:0]  io_status,
  input  logic               io_bad_phase,
  input  logic               tlp_len_err,
  input  logic               rx_ecc_err,
  input  logic               ur_err,
  input  logic               ca_err,
  input  logic               lba_unsup,
  input  logic               scan_done,
  input  logic [NDEV-1:0]    dev_live,
  output logic [ERR_W-1:0]   err_type,
  output logic               err_any,
  output logic [DEV_W-1:0]   err_dev,
  output logic [31:0]        cap_snap,
  output logic [WORD_W-1:0]  adm_word,
  output logic [WORD_W-1:0]  io_word
);
  logic             cap_fail_evt;
  logic             adm_bad_evt;
  logic             io_bad_evt;
  logic             tmr_armed;
  logic             adm_to_evt;
  logic             io_to_evt;
  logic             nodev_evt;
  logic [ERR_W-1:0] err_set;
  logic [ERR_W-1:0] err_next;
  logic             first_err;

  cep_cap_check u_cap (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_mqes(cap_mqes),
    .cap_dstrd(cap_dstrd), .cap_nvm_set(cap_nvm_set), .cap_mpsmin(cap_mpsmin),
    .fail_evt(cap_fail_evt), .snap(cap_snap)
  );

  cep_cpl_latch u_adm (
    .clk(clk), .rst_n(rst_n), .valid(adm_cpl_valid), .status(adm_status),
    .bad_tag(adm_bad_id), .bad_evt(adm_bad_evt), .word(adm_word)
  );

  cep_cpl_latch u_io (
    .clk(clk), .rst_n(rst_n), .valid(io_cpl_valid), .status(io_status),
    .bad_tag(io_bad_phase), .bad_evt(io_bad_evt), .word(io_word)
  );

  cep_wait_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .limit_in(timeout_limit), .start(wait_start),
    .start_is_io(wait_is_io), .done(cpl_seen), .armed(tmr_armed),
    .adm_expire(adm_to_evt), .io_expire(io_to_evt)
  );

  assign nodev_evt = scan_done && (dev_live == '0);

  always_comb begin
    err_set           = '0;
    err_set[B_NODEV]  = nodev_evt;
    err_set[B_CAP]    = cap_fail_evt;
    err_set[B_ADM_TO] = adm_to_evt;
    err_set[B_ADM_ST] = adm_bad_evt;
    err_set[B_IO_TO]  = io_to_evt;
    err_set[B_IO_ST]  = io_bad_evt;
    err_set[B_TLPLEN] = tlp_len_err;
    err_set[B_ECC]    = rx_ecc_err;
    err_set[B_UR]     = ur_err;
    err_set[B_CA]     = ca_err;
    err_set[B_LBA]    = lba_unsup;
  end

  assign err_next  = err_type | (err_set & ERR_MASK);
  assign first_err = (err_type == '0) && (err_set != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_type <= '0;
      err_any  <= 1'b0;
      err_dev  <= '0;
    end else begin
      err_type <= err_next;
      err_any  <= |err_next;
      if (first_err) err_dev <= dev_sel;
    end
  end
endmodule

// File: rtl/cep_checker.sv
module cep_checker
  import cep_pkg::*;
#(
  parameter int DEV_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ERR_W-1:0]   err_type,
  input logic               err_any,
  input logic [DEV_W-1:0]   err_dev,
  input logic [DEV_W-1:0]   dev_sel,
  input logic [ERR_W-1:0]   err_set,
  input logic               cap_valid,
  input logic [MQES_W-1:0]  cap_mqes,
  input logic [31:0]        cap_snap,
  input logic               wait_start,
  input logic [TO_W-1:0]    timeout_limit,
  input logic               tmr_armed,
  input logic               adm_cpl_valid,
  input logic [STAT_W-1:0]  adm_status,
  input logic               adm_bad_id,
  input logic [WORD_W-1:0]  adm_word
);
  // R10
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_type & $past(err_type)) == $past(err_type)));
  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_type & ~ERR_MASK) == '0);
  // R11
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (err_type != '0));
  // R12
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> $stable(err_dev));
  // R12
  dev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_type == '0) && (err_set != '0)) |=> (err_dev == $past(dev_sel)));
  // R3
  snap_mqes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (cap_snap[15:0] == $past(cap_mqes)));
  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_start && (timeout_limit == '0)) |=> !tmr_armed);
  // R4
  adm_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adm_cpl_valid |=> (adm_word == {$past(adm_status), $past(adm_bad_id)}));
endmodule

bind cmpl_err_collector cep_checker #(.DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_type(err_type), .err_any(err_any),
  .err_dev(err_dev), .dev_sel(dev_sel), .err_set(err_set),
  .cap_valid(cap_valid), .cap_mqes(cap_mqes), .cap_snap(cap_snap),
  .wait_start(wait_start), .timeout_limit(timeout_limit), .tmr_armed(tmr_armed),
  .adm_cpl_valid(adm_cpl_valid), .adm_status(adm_status), .adm_bad_id(adm_bad_id),
  .adm_word(adm_word)
);

// File: tb/cmpl_err_collector_test.sv
module cmpl_err_collector_test;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [1:0] dev_sel;
  logic [31:0] timeout_limit;
  logic wait_start, wait_is_io, cpl_seen, cap_valid, cap_nvm_set;
  logic [15:0] cap_mqes;
  logic [3:0] cap_dstrd, cap_mpsmin, dev_live;
  logic adm_cpl_valid, adm_bad_id, io_cpl_valid, io_bad_phase;
  logic [14:0] adm_status, io_status;
  logic tlp_len_err, rx_ecc_err, ur_err, ca_err, lba_unsup, scan_done;
  logic [31:0] err_type, cap_snap;
  logic err_any;
  logic [1:0] err_dev;
  logic [15:0] adm_word, io_word;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cmpl_err_collector uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    dev_sel = 0; timeout_limit = 0; wait_start = 0; wait_is_io = 0; cpl_seen = 0;
    cap_valid = 0; cap_nvm_set = 0; cap_mqes = 0; cap_dstrd = 0; cap_mpsmin = 0;
    adm_cpl_valid = 0; adm_bad_id = 0; adm_status = 0;
    io_cpl_valid = 0; io_bad_phase = 0; io_status = 0;
    tlp_len_err = 0; rx_ecc_err = 0; ur_err = 0; ca_err = 0; lba_unsup = 0;
    scan_done = 0; dev_live = 4'hF;
  endtask

  task automatic do_reset();
    rst_n = 0;
    clear_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic any_ok(input string req);
    chk(req, {31'd0, err_any}, {31'd0, (err_type != 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 err_type", err_type, 0);
    chk("R1 err_any", {31'd0, err_any}, 0);
    chk("R1 err_dev", {30'd0, err_dev}, 0);
    chk("R1 cap_snap", cap_snap, 0);
    chk("R1 words", {adm_word, io_word}, 0);

    // R2 / R3 capability grid
    for (int mp = 0; mp < 3; mp++)
      for (int ds = 0; ds < 3; ds++)
        for (int nv = 0; nv < 2; nv++)
          for (int mq = 0; mq < 10; mq++) begin
            logic bad;
            logic [31:0] pk;
            do_reset();
            cap_valid = 1; cap_mpsmin = 4'(mp); cap_dstrd = 4'(ds);
            cap_nvm_set = nv[0]; cap_mqes = 16'(mq * 1000 % 17 + (mq < 9 ? mq : 16'hFFF0));
            bad = (mp != 0) || (nv == 0) || (ds != 0) || (cap_mqes >= 7);
            pk = 32'(cap_mqes) + (32'(ds) << 16) + (32'(nv) << 20) + (32'(mp) << 21);
            @(negedge clk);
            cap_valid = 0;
            chk("R2 cap bit", err_type, bad ? 32'h2 : 32'h0);
            chk("R3 snapshot", cap_snap, pk);
          end
    // R2 exact boundary mqes 6 vs 7
    do_reset();
    cap_valid = 1; cap_nvm_set = 1; cap_mqes = 6;
    @(negedge clk); cap_valid = 0;
    chk("R2 mqes6 ok", err_type, 0);
    cap_valid = 1; cap_mqes = 7;
    @(negedge clk); cap_valid = 0;
    chk("R2 mqes7 bad", err_type, 32'h2);

    // R4 / R5 status words
    for (int s = 0; s < 6; s++)
      for (int f = 0; f < 2; f++) begin
        logic [14:0] sv;
        sv = (s == 5) ? 15'h7FFF : 15'(s * 3);
        do_reset();
        adm_cpl_valid = 1; adm_status = sv; adm_bad_id = f[0];
        @(negedge clk); adm_cpl_valid = 0;
        chk("R4 adm word", {16'd0, adm_word}, {16'd0, sv, f[0]});
        chk("R4 adm bit3", err_type, ((sv != 0) || f != 0) ? 32'h8 : 32'h0);
        io_cpl_valid = 1; io_status = sv ^ 15'h0001; io_bad_phase = ~f[0];
        @(negedge clk); io_cpl_valid = 0;
        chk("R5 io word", {16'd0, io_word}, {16'd0, sv ^ 15'h0001, ~f[0]});
        chk("R5 io bit5", err_type & 32'h20, 32'h20);
      end
    // R4 latch follows the newest completion
    do_reset();
    adm_cpl_valid = 1; adm_status = 15'h0ABC; adm_bad_id = 0;
    @(negedge clk);
    adm_status = 0;
    @(negedge clk); adm_cpl_valid = 0;
    chk("R4 overwrite", {16'd0, adm_word}, 0);
    chk("R10 sticky bit3", err_type, 32'h8);

    // R6 / R7 timer sweep
    for (int io = 0; io < 2; io++)
      for (int lim = 1; lim <= 6; lim++)
        for (int c = 1; c <= lim + 2; c++) begin
          logic [31:0] tob;
          tob = io ? 32'h10 : 32'h4;
          do_reset();
          timeout_limit = 32'(lim); wait_is_io = io[0]; wait_start = 1;
          @(negedge clk);
          wait_start = 0; timeout_limit = 32'd999;
          for (int j = 1; j <= lim + 3; j++) begin
            if (j == c) cpl_seen = 1;
            @(negedge clk);
            cpl_seen = 0;
            if (j == lim - 1) chk("R6 early", err_type, 0);
            if (j == lim) chk(c <= lim ? "R7 cancel" : "R6 expire", err_type, (c <= lim) ? 0 : tob);
          end
          chk("R10 timer final", err_type, (c <= lim) ? 0 : tob);
        end
    // R7 limit zero disables
    do_reset();
    timeout_limit = 0; wait_start = 1;
    @(negedge clk); wait_start = 0;
    repeat (60) @(negedge clk);
    chk("R7 zero limit", err_type, 0);
    // R6 restart reloads the count
    do_reset();
    timeout_limit = 5; wait_start = 1;
    @(negedge clk); wait_start = 0;
    repeat (3) @(negedge clk);
    wait_start = 1;
    @(negedge clk); wait_start = 0;
    repeat (4) @(negedge clk);
    chk("R6 reload early", err_type, 0);
    @(negedge clk);
    chk("R6 reload expire", err_type, 32'h4);

    // R8 packet strobes
    for (int k = 0; k < 5; k++) begin
      logic [31:0] ex;
      do_reset();
      case (k)
        0: begin tlp_len_err = 1; ex = 32'h40; end
        1: begin rx_ecc_err = 1; ex = 32'h80; end
        2: begin ur_err = 1; ex = 32'h100; end
        3: begin ca_err = 1; ex = 32'h200; end
        default: begin lba_unsup = 1; ex = 32'h10000; end
      endcase
      @(negedge clk);
      clear_inputs();
      chk("R8 strobe bit", err_type, ex);
      any_ok("R11 any");
    end

    // R9 drive scan
    do_reset();
    dev_live = 0; scan_done = 1;
    @(negedge clk); scan_done = 0;
    chk("R9 no drive", err_type, 32'h1);
    do_reset();
    dev_live = 4'b0100; scan_done = 1;
    @(negedge clk); scan_done = 0;
    chk("R9 drive found", err_type, 0);
    dev_live = 0;
    repeat (3) @(negedge clk);
    chk("R9 shutdown all", err_type, 0);
    chk("R11 idle flag", {31'd0, err_any}, 0);

    // R12 / R11 / R10 device capture and stickiness
    for (int d = 0; d < 4; d++) begin
      do_reset();
      dev_sel = 2'(d); rx_ecc_err = 1;
      @(negedge clk);
      rx_ecc_err = 0; dev_sel = 2'(d + 1); ur_err = 1;
      @(negedge clk);
      ur_err = 0;
      repeat (2) @(negedge clk);
      chk("R12 first device", {30'd0, err_dev}, 32'(d));
      chk("R10 both bits", err_type, 32'h180);
      any_ok("R11 any set");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule